// File: doc/BRIEF.md
# I2C Bus Event and SCL-Low Timeout Detector

This block watches a decoded I2C bus and measures two intervals in system clock cycles against one programmable limit. The first is the quiet time between bus events while a transaction is in flight. An event is a Start, a Stop, or a rising or falling edge on SCL. The second is the continuous time that SCL is held low, measured whether or not a transaction is in flight. When either interval runs past the limit, a sticky flag is raised. Software drops each flag with a one-cycle clear strobe, and an interrupt request is driven from the flags that are enabled.

The bus front end supplies single-cycle Start and Stop pulses and an SCL level that is already synchronized to the system clock. The bus counts as idle after reset or after a Stop, and as active after a Start. The event interval is not measured while the bus is idle. A limit of zero turns both detectors off.

The asynchronous active-low reset passes through a two-stage synchronizer, so the block leaves reset on a clock edge.

Top module: `i2c_tmo_watch`

## Requirements
- R1: After reset, `evt_flag`, `scl_flag` and `irq` are all 0.
- R2: While the bus is active and the limit L is nonzero, `evt_flag` becomes 1 on the first clock edge at which L+1 consecutive cycles have passed without a bus event. It is still 0 after only L such cycles.
- R3: A cycle with `start_pulse`, `stop_pulse`, a rising SCL edge or a falling SCL edge restarts the event interval from zero. An SCL edge is a change of `scl_sync` from one cycle to the next.
- R4: `evt_flag` is never set while the bus is idle. The bus is idle from reset until a Start, and again from each Stop. If Start and Stop arrive in the same cycle, Start wins.
- R5: When L is nonzero, `scl_flag` becomes 1 once `scl_sync` has been 0 for L+1 consecutive cycles. Any cycle with `scl_sync` at 1 restarts this count. The count runs whether the bus is idle or active.
- R6: Each expiry sets a flag only once. After the flag is cleared, it is not set again until its interval has been restarted and then runs out in full.
- R7: A cycle with `evt_clr` (or `scl_clr`) at 1 clears its flag on the next edge. If the same cycle also sets the flag, the set wins.
- R8: `irq` equals (`evt_flag` AND `evt_irq_en`) OR (`scl_flag` AND `scl_irq_en`), with no register delay.
- R9: A limit of 0 keeps both flags from being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_pulse | input | 1 | One-cycle pulse for a detected Start or repeated Start |
| stop_pulse | input | 1 | One-cycle pulse for a detected Stop |
| scl_sync | input | 1 | SCL level, already synchronized to clk |
| tmo_limit | input | CNT_W | Timeout limit in clk cycles; 0 turns both detectors off |
| evt_irq_en | input | 1 | Lets the event flag drive irq |
| scl_irq_en | input | 1 | Lets the SCL-low flag drive irq |
| evt_clr | input | 1 | Clear strobe for the event flag |
| scl_clr | input | 1 | Clear strobe for the SCL-low flag |
| evt_flag | output | 1 | Sticky flag: event interval ran out |
| scl_flag | output | 1 | Sticky flag: SCL-low time ran out |
| irq | output | 1 | Interrupt request built from the enabled flags |

## Verification
Input values present at clock edge t have their effect on the flags after edge t. An expiry found at edge t shows on its flag right after that edge, and clears act one edge after their strobe. `irq` follows the flags and enables within the same cycle. The bench drives inputs on the falling edge and compares a short settle time later. A cycle-level reference model is advanced on every rising edge from the same inputs, so each flag is compared in exactly the cycle after the edge that must change it, never a cycle early or late.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;
  // Slots used by the replicated timer/flag pairs
  typedef enum int {
    TMR_EVT = 0,
    TMR_SCL = 1
  } tmr_idx_e;

  localparam int NUM_TMR = 2;
endpackage

// File: rtl/i2c_tmo_busmon.sv
// Tracks bus activity from Start/Stop pulses and detects SCL edges.
module i2c_tmo_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic start_pulse,
  input  logic stop_pulse,
  input  logic scl_sync,
  output logic bus_active,
  output logic scl_edge
);
  logic active_q, active_d;
  logic scl_q;

  always_comb begin
    active_d = active_q;
    if (start_pulse)     active_d = 1'b1;
    else if (stop_pulse) active_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      scl_q    <= 1'b1;
    end else begin
      active_q <= active_d;
      scl_q    <= scl_sync;
    end
  end

  assign bus_active = active_q;
  assign scl_edge   = scl_q ^ scl_sync;

  // R4: Start takes priority and always marks the bus busy
  assert_start_activates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> bus_active);
  // R4: a lone Stop returns the bus to idle
  assert_stop_idles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pulse && !start_pulse) |=> !bus_active);
endmodule

// File: rtl/i2c_tmo_timer.sv
// Interval counter: held at zero by hold, fires expire once per run-out.
module i2c_tmo_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  assign expire = !hold && !done_q && (cnt_q >= limit);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (hold) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (expire) begin
      done_d = 1'b1;
    end else if (!done_q) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // R6: no second expiry straight after the first
  assert_single_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
  // R3: a hold cycle leaves the counter at zero
  assert_hold_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0));
endmodule

// File: rtl/i2c_tmo_flag.sv
// Sticky flag with write-1-to-clear strobe; set has priority.
module i2c_tmo_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
endmodule

// File: rtl/i2c_tmo_watch.sv
module i2c_tmo_watch
  import i2c_tmo_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_pulse,
  input  logic             stop_pulse,
  input  logic             scl_sync,
  input  logic [CNT_W-1:0] tmo_limit,
  input  logic             evt_irq_en,
  input  logic             scl_irq_en,
  input  logic             evt_clr,
  input  logic             scl_clr,
  output logic             evt_flag,
  output logic             scl_flag,
  output logic             irq
);
  // Reset synchronizer: asserts asynchronously, releases on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic bus_active, scl_edge, bus_event, lim_zero;

  i2c_tmo_busmon u_busmon (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start_pulse (start_pulse),
    .stop_pulse  (stop_pulse),
    .scl_sync    (scl_sync),
    .bus_active  (bus_active),
    .scl_edge    (scl_edge)
  );

  assign bus_event = start_pulse | stop_pulse | scl_edge;
  assign lim_zero  = (tmo_limit == '0);

  logic [NUM_TMR-1:0] hold, expire, clr, en, flag;

  assign hold[TMR_EVT] = lim_zero | bus_event | !bus_active;
  assign hold[TMR_SCL] = lim_zero | scl_sync;
  assign clr[TMR_EVT]  = evt_clr;
  assign clr[TMR_SCL]  = scl_clr;
  assign en[TMR_EVT]   = evt_irq_en;
  assign en[TMR_SCL]   = scl_irq_en;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_det
    i2c_tmo_timer #(.CNT_W(CNT_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .hold   (hold[g]),
      .limit  (tmo_limit),
      .expire (expire[g])
    );
    i2c_tmo_flag u_flag (
      .clk   (clk),
      .rst_n (rst_core_n),
      .set   (expire[g]),
      .clr   (clr[g]),
      .flag  (flag[g])
    );
  end

  assign evt_flag = flag[TMR_EVT];
  assign scl_flag = flag[TMR_SCL];
  assign irq      = |(flag & en);

  // R9: zero limit never raises a flag
  assert_zero_limit_evt_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    lim_zero |=> !$rose(evt_flag));
  assert_zero_limit_scl_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    lim_zero |=> !$rose(scl_flag));
  // R4: an event flag only rises out of an active bus
  assert_idle_no_evt_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!bus_active && !start_pulse) |=> !$rose(evt_flag));
  // R5: the SCL-low flag only rises after a cycle with SCL low
  assert_scl_low_only_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    scl_sync |=> !$rose(scl_flag));
endmodule

// File: tb/i2c_tmo_watch_test.sv
`timescale 1ns/1ps
module i2c_tmo_watch_test;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic start_pulse, stop_pulse, scl_sync;
  logic [CNT_W-1:0] tmo_limit;
  logic evt_irq_en, scl_irq_en, evt_clr, scl_clr;
  logic evt_flag, scl_flag, irq;

  always #10 clk = ~clk; // 50 MHz

  i2c_tmo_watch #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse), .stop_pulse(stop_pulse),
    .scl_sync(scl_sync), .tmo_limit(tmo_limit), .evt_irq_en(evt_irq_en),
    .scl_irq_en(scl_irq_en), .evt_clr(evt_clr), .scl_clr(scl_clr),
    .evt_flag(evt_flag), .scl_flag(scl_flag), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  string cur_req = "R1";

  // Reference model state
  bit m_act, m_sclp, m_ef, m_sf, m_efired, m_sfired;
  int m_eq, m_sq;

  function automatic bit exp_irq(bit ef, bit sf, bit ee, bit se);
    return (ef & ee) | (sf & se);
  endfunction

  task automatic chk(string what, bit act, bit exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic model_step(bit st, bit sp, bit sc, bit ce, bit cs, int lim);
    bit ev, efire, sfire;
    efire = 0; sfire = 0;
    ev = st | sp | (sc != m_sclp);
    if (lim == 0 || ev || !m_act) begin m_eq = 0; m_efired = 0; end
    else begin
      m_eq++;
      if (m_eq > lim && !m_efired) begin efire = 1; m_efired = 1; end
    end
    if (lim == 0 || sc) begin m_sq = 0; m_sfired = 0; end
    else begin
      m_sq++;
      if (m_sq > lim && !m_sfired) begin sfire = 1; m_sfired = 1; end
    end
    if (efire) m_ef = 1; else if (ce) m_ef = 0;
    if (sfire) m_sf = 1; else if (cs) m_sf = 0;
    if (st) m_act = 1; else if (sp) m_act = 0;
    m_sclp = sc;
  endtask

  // One clock: drive at negedge, compare, then advance model at posedge
  task automatic cyc(bit st, bit sp, bit sc, bit ce, bit cs);
    start_pulse = st; stop_pulse = sp; scl_sync = sc; evt_clr = ce; scl_clr = cs;
    #1;
    chk("evt_flag", evt_flag, m_ef);
    chk("scl_flag", scl_flag, m_sf);
    chk("irq (R8)", irq, exp_irq(m_ef, m_sf, evt_irq_en, scl_irq_en));
    @(posedge clk);
    model_step(st, sp, sc, ce, cs, int'(tmo_limit));
    @(negedge clk);
  endtask

  task automatic idle_n(int n, bit sc);
    for (int i = 0; i < n; i++) cyc(0, 0, sc, 0, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    int ticks = 0;
    while (ticks < 100000) begin @(posedge clk); ticks++; end
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 0; start_pulse = 0; stop_pulse = 0; scl_sync = 1;
    tmo_limit = 16'd4; evt_irq_en = 1; scl_irq_en = 1; evt_clr = 0; scl_clr = 0;
    m_act = 0; m_sclp = 1; m_ef = 0; m_sf = 0; m_efired = 0; m_sfired = 0; m_eq = 0; m_sq = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    #1; chk("evt_flag reset", evt_flag, 0); chk("scl_flag reset", scl_flag, 0); chk("irq reset", irq, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    idle_n(3, 1);

    cur_req = "R4"; // idle bus, SCL high steady: no event flag
    idle_n(20, 1);
    cyc(1, 1, 1, 0, 0); // start and stop together: start wins
    cur_req = "R2"; // active, quiet: flags after L+1 cycles
    idle_n(12, 1);
    cyc(0, 1, 1, 1, 0); // stop plus clear
    cur_req = "R4"; idle_n(15, 1);

    cur_req = "R3"; // start, then SCL toggling keeps restarting
    cyc(1, 0, 1, 0, 0);
    for (int i = 0; i < 10; i++) begin idle_n(3, 0); idle_n(3, 1); end
    idle_n(2, 1); cyc(1, 0, 1, 0, 0); idle_n(3, 1); cyc(0, 1, 1, 0, 0);

    cur_req = "R5"; // SCL low on idle bus
    idle_n(9, 0);
    cur_req = "R6"; // clear while still low: no refire
    cyc(0, 0, 0, 0, 1); idle_n(20, 0);
    idle_n(2, 1); idle_n(8, 0); idle_n(1, 1);
    cur_req = "R7"; // clear and set on same edge
    idle_n(4, 0);
    cyc(0, 0, 0, 0, 1); // L+1th low cycle with clear: set wins
    cyc(0, 0, 0, 0, 1);
    idle_n(2, 1);

    cur_req = "R8";
    evt_irq_en = 0; scl_irq_en = 0; idle_n(3, 1);
    idle_n(8, 0); scl_irq_en = 1; idle_n(2, 0); evt_irq_en = 1; scl_irq_en = 0; idle_n(2, 1);
    cyc(0, 0, 1, 0, 1); scl_irq_en = 1;

    cur_req = "R9";
    tmo_limit = 0; cyc(1, 0, 1, 0, 0); idle_n(40, 0); idle_n(5, 1); cyc(0, 1, 1, 0, 0);
    tmo_limit = 1; cur_req = "R2"; cyc(1, 0, 1, 0, 0); idle_n(4, 1); cyc(0, 1, 1, 1, 1);

    cur_req = "R3";
    for (int blk = 0; blk < 12; blk++) begin
      tmo_limit = 16'($urandom_range(1, 10));
      evt_irq_en = 1'($urandom_range(0, 1));
      scl_irq_en = 1'($urandom_range(0, 1));
      for (int i = 0; i < 400; i++) begin
        bit sc;
        sc = ($urandom_range(0, 9) < 2) ? ~scl_sync : scl_sync;
        cyc(($urandom_range(0, 49) == 0), ($urandom_range(0, 59) == 0), sc,
            ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0));
      end
    end
    summary();
  end
endmodule